// File: doc/BRIEF.md
# Instruction Prefetch Queue with Bus Fetch

This block sits between a slow memory bus and an instruction execution unit. A fetch sequencer on the bus side runs bus cycles of a fixed length. Each cycle reads the next sequential code bytes into a small circular queue, and a cycle starts whenever the queue will have space for what that cycle returns. On the execute side, bytes leave the queue in address order through a valid/ready handshake. The consumer stalls while the queue is empty, so its throughput then falls to the rate of the bus.

A redirect request models a taken branch. It throws away every queued byte and moves the fetch address to the target. A bus cycle already in flight is allowed to finish, but its data is dropped. The parameter `BUS_BYTES` selects the bus form. With one byte per cycle the queue is four deep. With two bytes per cycle the queue is six deep, bus addresses are even, and an odd target keeps only the upper byte of its first fetch.

Top module: `prefetch_queue`

## Requirements
- R1: In the first cycle after reset is released, `code_valid` is 0, `bus_req` is 1 and `bus_addr` equals `RESET_ADDR`.
- R2: A bus cycle lasts `BUS_CLKS` (4) clocks. `bus_req` is high only in its first clock, and `bus_addr` holds its value for the whole cycle. `bus_rdata` is sampled at the clock edge that ends the cycle, and the bytes are visible at `code_byte` from the next cycle on.
- R3: The queue never holds more than 4 bytes (one-byte form) or 6 bytes (two-byte form). A new bus cycle starts only if, after the current edge's writes and pops, at least `BUS_BYTES` entries are free. With no consumption, the queue fills to capacity and `bus_req` then stays low.
- R4: Bytes leave in ascending address order, and each byte equals the memory content at its address. A byte is consumed in a cycle where `code_valid` and `code_ready` are both high. While it is not consumed, `code_valid` and `code_byte` hold their values.
- R5: In the two-byte form, every `bus_addr` is even. `bus_rdata[7:0]` is the byte at `bus_addr` and `bus_rdata[15:8]` is the byte at `bus_addr`+1. The fetch address advances by 2 per cycle.
- R6: In the cycle after `redir` is high, `code_valid` is 0.
- R7: A bus cycle in progress when `redir` arrives runs to its end and its data is dropped. The next `bus_req` comes in the cycle after that end, at the target address (aligned down to even in the two-byte form).
- R8: In the two-byte form, for an odd target, only the upper byte of the first fetch enters the queue. The first byte delivered after the redirect is therefore the byte at the target.
- R9: When `redir` and a `code_valid`/`code_ready` handshake fall in the same cycle, the redirect wins. The first byte delivered afterwards is the byte at the target.
- R10: Fetching overlaps consumption. With `code_ready` held high, bus cycles run back to back, giving exactly 10 `bus_req` pulses in any 40 consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| redir | input | 1 | Flush the queue and redirect fetching |
| redir_addr | input | ADDR_W | Redirect target address |
| code_valid | output | 1 | A code byte is available |
| code_ready | input | 1 | Consumer takes the byte this cycle |
| code_byte | output | 8 | Oldest queued code byte |
| bus_addr | output | ADDR_W | Address of the current bus cycle |
| bus_req | output | 1 | Strobe in the first clock of a bus cycle |
| bus_rdata | input | 8*BUS_BYTES | Bus read data, sampled on the last clock of the cycle |

## Verification
Two pairs of functions can fall in the same cycle. A redirect can coincide with a consumer handshake, and it can land in the final clock of a bus cycle, where a write and a new fetch start would otherwise happen together. The bench holds `code_ready` low to fill the queue and then raises the redirect together with the ready. In the random phase, redirects land on every bus phase. A behavioural model with a byte queue judges every cycle of both bus forms: the redirect must win, the in-flight data must vanish, and the first byte delivered must be the one at the target.

// File: rtl/pfq_pkg.sv
// Package: shared sizing helpers for the prefetch queue.
// Assumes a bus form of one or two bytes per bus cycle.
package pfq_pkg;
    // Width of the per-edge write count (0, 1 or 2 bytes).
    localparam int WR_CNT_W = 2;

    // Queue depth that belongs to each bus form.
    function automatic int queue_depth(input int bus_bytes);
        return (bus_bytes == 1) ? 4 : 6;
    endfunction
endpackage

// File: rtl/pfq_store.sv
// Module: circular byte store with multi-byte write and single-byte read.
// Assumes the caller never writes more than the free space and never
// pops when empty; clear empties the store and overrides write and pop.
module pfq_store #(
    parameter int DEPTH  = 4,
    parameter int WR_MAX = 1,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clear,
    input  logic [pfq_pkg::WR_CNT_W-1:0] wr_cnt,
    input  logic [8*WR_MAX-1:0]       wr_data,
    input  logic                      pop,
    output logic                      rd_valid,
    output logic [7:0]                rd_data,
    output logic [CNT_W-1:0]          count,
    output logic [CNT_W-1:0]          count_next
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [7:0]       mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    // Advance a pointer by n places, wrapping at DEPTH.
    function automatic logic [PTR_W-1:0] adv(input logic [PTR_W-1:0] p, input int n);
        int s;
        s = int'(p) + n;
        if (s >= DEPTH) s = s - DEPTH;
        return PTR_W'(s);
    endfunction

    // Occupancy after this edge.
    always_comb begin
        if (clear) count_next = '0;
        else       count_next = count + CNT_W'(wr_cnt) - CNT_W'(pop);
    end

    // Byte storage, written lane by lane.
    always_ff @(posedge clk) begin
        for (int k = 0; k < WR_MAX; k++) begin
            if (!clear && (k < int'(wr_cnt))) mem[adv(wr_ptr, k)] <= wr_data[8*k +: 8];
        end
    end

    // Pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            wr_ptr <= adv(wr_ptr, int'(wr_cnt));
            if (pop) rd_ptr <= adv(rd_ptr, 1);
            count <= count_next;
        end
    end

    assign rd_valid = (count != '0);
    assign rd_data  = mem[rd_ptr];
endmodule

// File: rtl/pfq_fetch.sv
// Module: bus fetch sequencer. Runs bus cycles of BUS_CLKS clocks,
// strobes bus_req in the first clock and samples data in the last.
// Assumes room_ok reflects occupancy after the current edge; a redirect
// marks an unfinished cycle for discard and reloads the fetch address.
module pfq_fetch #(
    parameter int             ADDR_W     = 16,
    parameter int             BUS_BYTES  = 1,
    parameter int             BUS_CLKS   = 4,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         redir,
    input  logic [ADDR_W-1:0]            redir_addr,
    input  logic                         room_ok,
    input  logic [8*BUS_BYTES-1:0]       bus_rdata,
    output logic [ADDR_W-1:0]            bus_addr,
    output logic                         bus_req,
    output logic [pfq_pkg::WR_CNT_W-1:0] wr_cnt,
    output logic [8*BUS_BYTES-1:0]       wr_data
);
    localparam int PH_W = (BUS_CLKS > 1) ? $clog2(BUS_CLKS) : 1;

    logic              busy;
    logic [PH_W-1:0]   phase;
    logic              discard;
    logic              skip_low;
    logic [ADDR_W-1:0] fetch_addr;
    logic [ADDR_W-1:0] src_addr;
    logic [ADDR_W-1:0] base_addr;
    logic              end_now;
    logic              keep;
    logic              start;

    // Cycle boundary, kept data and start decision.
    always_comb begin
        end_now  = busy && (phase == PH_W'(BUS_CLKS - 1));
        keep     = end_now && !discard && !redir;
        start    = (!busy || end_now) && room_ok;
        src_addr = redir ? redir_addr : fetch_addr;
        base_addr = src_addr;
        if (BUS_BYTES == 2) base_addr[0] = 1'b0;
        if (!keep)         wr_cnt = '0;
        else if (skip_low) wr_cnt = pfq_pkg::WR_CNT_W'(1);
        else               wr_cnt = pfq_pkg::WR_CNT_W'(BUS_BYTES);
    end

    // Data lanes for the queue: the odd first fetch shifts its upper byte down.
    generate
        if (BUS_BYTES == 2) begin : g_wide
            assign wr_data = skip_low ? {8'h00, bus_rdata[15:8]} : bus_rdata;
        end else begin : g_narrow
            assign wr_data = bus_rdata;
        end
    endgenerate

    // Bus cycle state, fetch address and discard marking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            phase      <= '0;
            discard    <= 1'b0;
            skip_low   <= 1'b0;
            bus_addr   <= RESET_ADDR;
            fetch_addr <= RESET_ADDR;
        end else if (start) begin
            busy       <= 1'b1;
            phase      <= '0;
            discard    <= 1'b0;
            skip_low   <= (BUS_BYTES == 2) && src_addr[0];
            bus_addr   <= base_addr;
            fetch_addr <= base_addr + ADDR_W'(BUS_BYTES);
        end else begin
            if (end_now)   busy  <= 1'b0;
            else if (busy) phase <= phase + PH_W'(1);
            if (redir) fetch_addr <= redir_addr;
            if (redir && busy && !end_now) discard <= 1'b1;
        end
    end

    assign bus_req = busy && (phase == '0);
endmodule

// File: rtl/prefetch_queue.sv
// Module: instruction prefetch queue top. Joins the fetch sequencer to
// the byte store and gives redirect priority over a consumer pop.
// Assumes BUS_BYTES is 1 or 2; depth follows from the bus form.
module prefetch_queue #(
    parameter int                BUS_BYTES  = 1,
    parameter int                ADDR_W     = 16,
    parameter int                BUS_CLKS   = 4,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   redir,
    input  logic [ADDR_W-1:0]      redir_addr,
    output logic                   code_valid,
    input  logic                   code_ready,
    output logic [7:0]             code_byte,
    output logic [ADDR_W-1:0]      bus_addr,
    output logic                   bus_req,
    input  logic [8*BUS_BYTES-1:0] bus_rdata
);
    localparam int DEPTH = pfq_pkg::queue_depth(BUS_BYTES);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [pfq_pkg::WR_CNT_W-1:0] wr_cnt;
    logic [8*BUS_BYTES-1:0]       wr_data;
    logic [CNT_W-1:0]             q_count;
    logic [CNT_W-1:0]             q_count_next;
    logic                         pop;
    logic                         room_ok;

    // Redirect beats the handshake; room is judged after this edge.
    assign pop     = code_valid && code_ready && !redir;
    assign room_ok = (q_count_next <= CNT_W'(DEPTH - BUS_BYTES));

    pfq_fetch #(
        .ADDR_W    (ADDR_W),
        .BUS_BYTES (BUS_BYTES),
        .BUS_CLKS  (BUS_CLKS),
        .RESET_ADDR(RESET_ADDR)
    ) i_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .redir     (redir),
        .redir_addr(redir_addr),
        .room_ok   (room_ok),
        .bus_rdata (bus_rdata),
        .bus_addr  (bus_addr),
        .bus_req   (bus_req),
        .wr_cnt    (wr_cnt),
        .wr_data   (wr_data)
    );

    pfq_store #(
        .DEPTH (DEPTH),
        .WR_MAX(BUS_BYTES),
        .CNT_W (CNT_W)
    ) i_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (redir),
        .wr_cnt    (wr_cnt),
        .wr_data   (wr_data),
        .pop       (pop),
        .rd_valid  (code_valid),
        .rd_data   (code_byte),
        .count     (q_count),
        .count_next(q_count_next)
    );
endmodule

// File: rtl/prefetch_queue_chk.sv
// Module: property checker for the prefetch queue, bound to the top.
// Assumes BUS_CLKS of at least 2.
module prefetch_queue_chk #(
    parameter int BUS_BYTES = 1,
    parameter int ADDR_W    = 16,
    parameter int BUS_CLKS  = 4,
    parameter int DEPTH     = 4,
    parameter int CNT_W     = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              redir,
    input logic              code_valid,
    input logic              code_ready,
    input logic [7:0]        code_byte,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_req,
    input logic [CNT_W-1:0]  count
);
    int   gap;
    logic seen;

    // Clocks since the last bus strobe, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap  <= 0;
            seen <= 1'b0;
        end else if (bus_req) begin
            gap  <= 0;
            seen <= 1'b1;
        end else if (gap < BUS_CLKS) begin
            gap <= gap + 1;
        end
    end

    p_bus_cycle_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && seen) |-> (gap >= BUS_CLKS - 1));

    p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_req && seen) |-> $stable(bus_addr));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count) <= DEPTH);

    p_hold_unpopped_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (code_valid && !code_ready && !redir) |=> (code_valid && $stable(code_byte)));

    p_even_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> ((BUS_BYTES == 1) || !bus_addr[0]));

    p_redir_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
        redir |=> !code_valid);
endmodule

bind prefetch_queue prefetch_queue_chk #(
    .BUS_BYTES(BUS_BYTES),
    .ADDR_W   (ADDR_W),
    .BUS_CLKS (BUS_CLKS),
    .DEPTH    (DEPTH),
    .CNT_W    (CNT_W)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .redir     (redir),
    .code_valid(code_valid),
    .code_ready(code_ready),
    .code_byte (code_byte),
    .bus_addr  (bus_addr),
    .bus_req   (bus_req),
    .count     (q_count)
);

// File: tb/pfq_bench_lane.sv
`timescale 1ns/1ps
// Bench lane: one design instance, a memory model on its bus and a
// behavioural reference model compared at every falling edge.
module pfq_bench_lane #(
    parameter int BB   = 1,
    parameter int LANE = 0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        redir,
    input  logic [15:0] redir_addr,
    input  logic        code_ready,
    output logic        ov,
    output logic [7:0]  od,
    output logic        breq,
    output logic [15:0] baddr,
    output int          vecs,
    output int          bad
);
    localparam int DEPTH = (BB == 1) ? 4 : 6;

    logic [8*BB-1:0] bdata;

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return a[7:0] * 8'd29 + a[15:8] + 8'h3C;
    endfunction

    always_comb begin
        for (int k = 0; k < BB; k++) bdata[8*k +: 8] = mem_byte(baddr + 16'(k));
    end

    prefetch_queue #(.BUS_BYTES(BB)) i_prefetch_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .redir     (redir),
        .redir_addr(redir_addr),
        .code_valid(ov),
        .code_ready(code_ready),
        .code_byte (od),
        .bus_addr  (baddr),
        .bus_req   (breq),
        .bus_rdata (bdata)
    );

    logic [7:0]  q[$];
    logic        m_busy, m_discard, m_skip;
    int          m_phase;
    logic [15:0] m_addr, m_fetch;

    initial begin
        vecs = 0;
        bad  = 0;
        m_busy = 0; m_discard = 0; m_skip = 0; m_phase = 0;
        m_addr = 0; m_fetch = 0;
    end

    // Reference model, advanced at each rising edge.
    always @(posedge clk) begin
        logic        end_now;
        logic [15:0] base;
        if (!rst_n) begin
            q.delete();
            m_busy = 0; m_discard = 0; m_skip = 0; m_phase = 0;
            m_addr = 0; m_fetch = 0;
        end else begin
            end_now = m_busy && (m_phase == 3);
            if (!redir && q.size() > 0 && code_ready) void'(q.pop_front());
            if (end_now && !m_discard && !redir)
                for (int k = (m_skip ? 1 : 0); k < BB; k++) q.push_back(mem_byte(m_addr + 16'(k)));
            if (redir) q.delete();
            if (redir && m_busy && !end_now) m_discard = 1;
            if (redir) m_fetch = redir_addr;
            if (end_now) m_busy = 0;
            else if (m_busy) m_phase++;
            if (!m_busy && q.size() <= DEPTH - BB) begin
                base = m_fetch;
                if (BB == 2) base[0] = 1'b0;
                m_skip    = (BB == 2) && m_fetch[0];
                m_addr    = base;
                m_fetch   = base + 16'(BB);
                m_busy    = 1;
                m_phase   = 0;
                m_discard = 0;
            end
        end
    end

    // Compare outputs to the model away from the rising edge.
    always @(negedge clk) begin
        if (rst_n) begin
            vecs++;
            if (breq !== (m_busy && m_phase == 0)) begin
                bad++;
                $display("FAIL R2 lane%0d bus_req got %0b exp %0b", LANE, breq, m_busy && m_phase == 0);
            end
            if (m_busy) begin
                vecs++;
                if (baddr !== m_addr) begin
                    bad++;
                    $display("FAIL R5/R7 lane%0d bus_addr got %h exp %h", LANE, baddr, m_addr);
                end
            end
            vecs++;
            if (ov !== (q.size() > 0)) begin
                bad++;
                $display("FAIL R3 lane%0d code_valid got %0b exp %0b", LANE, ov, q.size() > 0);
            end
            if (q.size() > 0) begin
                vecs++;
                if (od !== q[0]) begin
                    bad++;
                    $display("FAIL R4 lane%0d code_byte got %h exp %h", LANE, od, q[0]);
                end
            end
        end
    end
endmodule

// File: tb/test_prefetch_queue.sv
`timescale 1ns/1ps
// Top bench: drives both bus forms with shared stimulus and adds
// directed checks for reset, fill, rate and redirect corner cases.
module test_prefetch_queue;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        redir = 1'b0;
    logic [15:0] redir_addr = 16'h0;
    logic        code_ready = 1'b0;

    logic        n_ov, w_ov, n_breq, w_breq;
    logic [7:0]  n_od, w_od;
    logic [15:0] n_baddr, w_baddr;
    int          n_vecs, n_bad, w_vecs, w_bad;
    int          checks = 0;
    int          fails = 0;
    logic        done = 1'b0;

    always #10 clk = ~clk;

    pfq_bench_lane #(.BB(1), .LANE(0)) u_narrow (
        .clk(clk), .rst_n(rst_n), .redir(redir), .redir_addr(redir_addr),
        .code_ready(code_ready), .ov(n_ov), .od(n_od), .breq(n_breq),
        .baddr(n_baddr), .vecs(n_vecs), .bad(n_bad));

    pfq_bench_lane #(.BB(2), .LANE(1)) u_wide (
        .clk(clk), .rst_n(rst_n), .redir(redir), .redir_addr(redir_addr),
        .code_ready(code_ready), .ov(w_ov), .od(w_od), .breq(w_breq),
        .baddr(w_baddr), .vecs(w_vecs), .bad(w_bad));

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return a[7:0] * 8'd29 + a[15:8] + 8'h3C;
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s got %0h exp %0h", tag, got, exp);
        end
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==",
                 checks + n_vecs + w_vecs, fails + n_bad + w_bad);
        $finish;
    endtask

    // Wait for the first byte on one lane and check it against a target.
    task automatic first_byte(input string tag, input int lane, input logic [15:0] tgt);
        int   seen_it;
        seen_it = 0;
        for (int i = 0; i < 20 && seen_it == 0; i++) begin
            if ((lane == 0 && n_ov) || (lane == 1 && w_ov)) begin
                seen_it = 1;
                chk(tag, lane == 0 ? n_od : w_od, mem_byte(tgt));
            end else begin
                tick();
            end
        end
        if (seen_it == 0) chk({tag, " no byte"}, 0, 1);
    endtask

    initial begin
        int pulses_n, pulses_w;
        repeat (4) tick();
        rst_n = 1'b1;
        tick();
        // R1: state just after reset
        chk("R1 narrow code_valid", n_ov, 0);
        chk("R1 narrow bus_req", n_breq, 1);
        chk("R1 narrow bus_addr", n_baddr, 0);
        chk("R1 wide code_valid", w_ov, 0);
        chk("R1 wide bus_req", w_breq, 1);

        // R3: fill with no consumption, then no more requests
        repeat (30) tick();
        pulses_n = 0; pulses_w = 0;
        for (int i = 0; i < 20; i++) begin
            pulses_n += n_breq; pulses_w += w_breq;
            tick();
        end
        chk("R3 narrow requests when full", pulses_n, 0);
        chk("R3 wide requests when full", pulses_w, 0);
        chk("R3 narrow valid when full", n_ov, 1);

        // R10: streaming consumption keeps the bus busy back to back
        code_ready = 1'b1;
        repeat (20) tick();
        pulses_n = 0; pulses_w = 0;
        for (int i = 0; i < 40; i++) begin
            pulses_n += n_breq; pulses_w += w_breq;
            tick();
        end
        chk("R10 narrow bus cycles in 40 clocks", pulses_n, 10);
        chk("R10 wide bus cycles in 40 clocks", pulses_w, 10);

        // R7: redirect in the second clock of a narrow bus cycle
        for (int i = 0; i < 8 && !n_breq; i++) tick();
        tick();
        redir = 1'b1; redir_addr = 16'h2000;
        tick();
        redir = 1'b0;
        chk("R6 narrow valid after redirect", n_ov, 0);
        chk("R6 wide valid after redirect", w_ov, 0);
        chk("R7 no request in third clock", n_breq, 0);
        tick();
        chk("R7 no request in last clock", n_breq, 0);
        tick();
        chk("R7 discarded data not queued", n_ov, 0);
        chk("R7 new request after cycle end", n_breq, 1);
        chk("R7 new request at target", n_baddr, 16'h2000);

        // R9 and R8: fill, then redirect to an odd target while popping
        code_ready = 1'b0;
        repeat (30) tick();
        chk("R9 precondition narrow valid", n_ov, 1);
        code_ready = 1'b1; redir = 1'b1; redir_addr = 16'h0101;
        tick();
        redir = 1'b0;
        fork
            first_byte("R9 narrow first byte after redirect", 0, 16'h0101);
            first_byte("R8 wide odd target first byte", 1, 16'h0101);
        join

        // Mixed phase: random ready and redirects across all bus phases
        for (int i = 0; i < 600; i++) begin
            code_ready = $urandom_range(0, 1);
            redir = ($urandom_range(0, 11) == 0);
            redir_addr = 16'($urandom);
            tick();
        end
        redir = 1'b0;
        repeat (10) tick();
        done = 1'b1;
        report();
    end

    // Watchdog: a hung run ends as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired got 0 exp 1");
            report();
        end
    end
endmodule